// File: doc/BRIEF.md
# Firmware/OS Event Handshake Registers

This block holds two small control registers that let two software agents signal each other. One register belongs to the operating-system side and the other to the firmware side. Each agent owns an enable bit and a status bit in its own register. Each agent can also set a release bit that reaches into the other agent's domain.

When firmware sets its release bit, the OS-side status bit is set as well. A system-control interrupt (`sci_out`) is then raised if the OS has enabled it. When the OS sets its release bit, the firmware-side status bit is set. A system-management interrupt (`smi_out`) is then raised if firmware has enabled it. Each agent acknowledges by writing 1 to its own status bit. That write clears the status bit and also the partner's release bit, which drops the interrupt.

Access is through a simple synchronous port: an address, write data and a write strobe. Read data is combinational from the current register state.

Top module: `evhs_regs`

## Requirements
- R1: After a synchronous active-high reset, every register bit reads 0 and both `sci_out` and `smi_out` are 0.
- R2: Bit 0 at offset 0 (OS enable) and bit 0 at offset 1 (firmware enable) are plain read/write. Writing either offset loads that bit from `wdata[0]`.
- R3: Writing 1 to offset 1 bit 2 (firmware release) sets that bit and also sets offset 0 bit 1 (OS status). Writing 0 to that bit changes neither bit.
- R4: Writing 1 to offset 0 bit 1 (OS status) clears that bit and also clears offset 1 bit 2 (firmware release). Writing 0 to that bit changes neither bit.
- R5: Writing 1 to offset 0 bit 2 (OS release) sets that bit and also sets offset 1 bit 1 (firmware status). Writing 0 to that bit changes neither bit.
- R6: Writing 1 to offset 1 bit 1 (firmware status) clears that bit and also clears offset 0 bit 2 (OS release). Writing 0 to that bit changes neither bit.
- R7: `sci_out` equals firmware release AND OS enable. It is registered, so it shows a state change one clock edge after the edge that stored that change.
- R8: `smi_out` equals OS release AND firmware enable, with the same one-edge registered latency as R7.
- R9: Bits 7..3 at offsets 0 and 1 read 0. Offsets 2 and 3 read 0, and writes to them change no state.
- R10: Reads have no side effects. Register contents and interrupt outputs are unchanged by any number of reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W (2) | Register offset |
| wdata | input | DATA_W (8) | Write data |
| wr_en | input | 1 | Write strobe, one write per cycle while high |
| rdata | output | DATA_W (8) | Read data for `addr` |
| sci_out | output | 1 | Level interrupt to the OS side |
| smi_out | output | 1 | Level interrupt to the firmware side |

## Verification
The in-RTL properties check the cross-register coupling on every cycle:
- a status write-1 always leaves the status bit clear;
- a peer release always sets the status bit;
- a status acknowledge always clears the peer's release bit;
- a release bit never rises without a write of 1;
- enables hold when not written;
- each interrupt tracks the previous cycle's release-and-enable product.

Only the bench's scenarios show the remaining behaviours:
- that the register map sits at the stated offsets and bit positions;
- that unused offsets and bits read 0;
- that reads leave state untouched;
- that a sweep over every write value at every offset gives the modelled end state.

// File: rtl/evhs_pkg.sv
package evhs_pkg;

    // Handshake bits of one side; packed so that bit 0 = enable,
    // bit 1 = status (write-1-to-clear), bit 2 = release (write-1-to-set)
    typedef struct packed {
        logic rel;
        logic sts;
        logic en;
    } hs_bits_t;

    localparam int HS_W   = $bits(hs_bits_t);
    localparam int SIDE_N = 2;

    // Side indices double as register offsets
    localparam int SIDE_OS = 0;
    localparam int SIDE_FW = 1;

    function automatic int peer_of(input int side);
        return (SIDE_N - 1) - side;
    endfunction

endpackage

// File: rtl/evhs_side.sv
module evhs_side
    import evhs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_sel,
    input  hs_bits_t wr_bits,
    input  logic     peer_rel_set,
    input  logic     peer_sts_clr,
    output logic     rel_set_evt,
    output logic     sts_clr_evt,
    output hs_bits_t bits_q
);

    hs_bits_t bits_d;

    assign rel_set_evt = wr_sel && wr_bits.rel;
    assign sts_clr_evt = wr_sel && wr_bits.sts;

    always_comb begin
        bits_d = bits_q;
        if (wr_sel)
            bits_d.en = wr_bits.en;
        // status: set by peer release, clear wins on conflict
        if (peer_rel_set)
            bits_d.sts = 1'b1;
        if (sts_clr_evt)
            bits_d.sts = 1'b0;
        // release: set by own write, cleared by peer acknowledge (wins)
        if (rel_set_evt)
            bits_d.rel = 1'b1;
        if (peer_sts_clr)
            bits_d.rel = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            bits_q <= '0;
        else
            bits_q <= bits_d;
    end

    a_r4_sts_cleared: assert property (@(posedge clk) disable iff (rst)
        sts_clr_evt |=> !bits_q.sts);

    a_r3_sts_set_by_peer: assert property (@(posedge clk) disable iff (rst)
        (peer_rel_set && !sts_clr_evt) |=> bits_q.sts);

    a_r6_rel_cleared_by_peer: assert property (@(posedge clk) disable iff (rst)
        peer_sts_clr |=> !bits_q.rel);

    a_r5_rel_rise_needs_write: assert property (@(posedge clk) disable iff (rst)
        $rose(bits_q.rel) |-> $past(wr_sel && wr_bits.rel));

    a_r2_en_holds: assert property (@(posedge clk) disable iff (rst)
        !wr_sel |=> $stable(bits_q.en));

endmodule

// File: rtl/evhs_irq.sv
module evhs_irq (
    input  logic clk,
    input  logic rst,
    input  logic rel,
    input  logic en,
    output logic irq_q
);

    always_ff @(posedge clk) begin
        if (rst)
            irq_q <= 1'b0;
        else
            irq_q <= rel && en;
    end

endmodule

// File: rtl/evhs_regs.sv
module evhs_regs
    import evhs_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    output logic [DATA_W-1:0] rdata,
    output logic              sci_out,
    output logic              smi_out
);

    localparam int PAD_W = DATA_W - HS_W;

    hs_bits_t side_q      [SIDE_N];
    logic     wr_sel      [SIDE_N];
    logic     rel_set_evt [SIDE_N];
    logic     sts_clr_evt [SIDE_N];
    logic     irq_q       [SIDE_N];

    hs_bits_t wr_bits;
    assign wr_bits = hs_bits_t'(wdata[HS_W-1:0]);

    for (genvar i = 0; i < SIDE_N; i++) begin : g_side
        localparam int PEER = peer_of(i);

        assign wr_sel[i] = wr_en && (addr == ADDR_W'(i));

        evhs_side u_side (
            .clk          (clk),
            .rst          (rst),
            .wr_sel       (wr_sel[i]),
            .wr_bits      (wr_bits),
            .peer_rel_set (rel_set_evt[PEER]),
            .peer_sts_clr (sts_clr_evt[PEER]),
            .rel_set_evt  (rel_set_evt[i]),
            .sts_clr_evt  (sts_clr_evt[i]),
            .bits_q       (side_q[i])
        );

        // interrupt toward the peer: own release gated by peer enable
        evhs_irq u_irq (
            .clk   (clk),
            .rst   (rst),
            .rel   (side_q[i].rel),
            .en    (side_q[PEER].en),
            .irq_q (irq_q[i])
        );
    end

    assign sci_out = irq_q[SIDE_FW];
    assign smi_out = irq_q[SIDE_OS];

    always_comb begin
        rdata = '0;
        for (int s = 0; s < SIDE_N; s++) begin
            if (addr == ADDR_W'(s))
                rdata = {{PAD_W{1'b0}}, side_q[s]};
        end
    end

    a_r7_sci_tracks: assert property (@(posedge clk) disable iff (rst)
        sci_out == $past(side_q[SIDE_FW].rel && side_q[SIDE_OS].en));

    a_r8_smi_tracks: assert property (@(posedge clk) disable iff (rst)
        smi_out == $past(side_q[SIDE_OS].rel && side_q[SIDE_FW].en));

    a_r9_spare_wr_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr >= ADDR_W'(SIDE_N)) |=>
            ($stable(side_q[SIDE_OS]) && $stable(side_q[SIDE_FW])));

endmodule

// File: tb/evhs_regs_tb.sv
module evhs_regs_tb_top;

    localparam int ADDR_W = 2;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] rdata;
    logic              sci_out;
    logic              smi_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // bench model: [2] release, [1] status, [0] enable
    logic [2:0] m_os = '0;
    logic [2:0] m_fw = '0;

    always #5 clk = ~clk;

    evhs_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rdata(rdata), .sci_out(sci_out), .smi_out(smi_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    function automatic logic exp_sci();
        return m_fw[2] & m_os[0];
    endfunction

    function automatic logic exp_smi();
        return m_os[2] & m_fw[0];
    endfunction

    task automatic model_write(input int a, input logic [7:0] d);
        if (a == 0) begin
            m_os[0] = d[0];
            if (d[1]) begin m_os[1] = 1'b0; m_fw[2] = 1'b0; end
            if (d[2]) begin m_os[2] = 1'b1; m_fw[1] = 1'b1; end
        end else if (a == 1) begin
            m_fw[0] = d[0];
            if (d[1]) begin m_fw[1] = 1'b0; m_os[2] = 1'b0; end
            if (d[2]) begin m_fw[2] = 1'b1; m_os[1] = 1'b1; end
        end
    endtask

    task automatic rd(input int a, output logic [7:0] v);
        @(negedge clk);
        addr = ADDR_W'(a);
        #1 v = rdata;
    endtask

    // write, check registered interrupt latency (R7, R8)
    task automatic wr(input int a, input logic [7:0] d);
        logic old_sci, old_smi;
        old_sci = exp_sci();
        old_smi = exp_smi();
        @(negedge clk);
        addr  = ADDR_W'(a);
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, d);
        chk("R7 sci before latency", 32'(sci_out), 32'(old_sci));
        chk("R8 smi before latency", 32'(smi_out), 32'(old_smi));
        @(negedge clk);
        chk("R7 sci after write", 32'(sci_out), 32'(exp_sci()));
        chk("R8 smi after write", 32'(smi_out), 32'(exp_smi()));
    endtask

    task automatic chk_regs(input string tag);
        logic [7:0] v;
        rd(0, v); chk({tag, " off0"}, 32'(v), {29'b0, m_os});
        rd(1, v); chk({tag, " off1"}, 32'(v), {29'b0, m_fw});
    endtask

    initial begin
        #(10 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        logic [7:0] v;
        logic [7:0] lfsr;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk_regs("R1 reset");
        chk("R1 sci reset", 32'(sci_out), 0);
        chk("R1 smi reset", 32'(smi_out), 0);

        // R2 enables
        wr(0, 8'h01); chk_regs("R2 os enable");
        wr(1, 8'h01); chk_regs("R2 fw enable");

        // R3 firmware release sets OS status; sci raised (R7)
        wr(1, 8'h05); chk_regs("R3 fw release");
        chk("R7 sci high", 32'(sci_out), 1);
        wr(1, 8'h01); chk_regs("R3 zero no effect");

        // R4 OS status acknowledge
        wr(0, 8'h01); chk_regs("R4 zero no effect");
        wr(0, 8'h03); chk_regs("R4 ack clears release");
        chk("R7 sci dropped", 32'(sci_out), 0);

        // R5 OS release sets firmware status; smi raised (R8)
        wr(0, 8'h05); chk_regs("R5 os release");
        chk("R8 smi high", 32'(smi_out), 1);
        wr(0, 8'h01); chk_regs("R5 zero no effect");
        wr(1, 8'h01); chk_regs("R6 zero no effect");
        wr(1, 8'h00); chk_regs("R8 enable gate");
        chk("R8 smi gated", 32'(smi_out), 0);
        wr(1, 8'h02); chk_regs("R6 ack clears release");

        // R9 spare offsets and bits
        wr(1, 8'h05);
        wr(2, 8'hFF); wr(3, 8'hFF);
        chk_regs("R9 spare write ignored");
        rd(2, v); chk("R9 off2 reads 0", 32'(v), 0);
        rd(3, v); chk("R9 off3 reads 0", 32'(v), 0);
        wr(0, 8'hF8); chk_regs("R9 upper bits");

        // R10 reads have no side effects
        wr(0, 8'h01);
        for (int k = 0; k < 8; k++) rd(k % 4, v);
        chk_regs("R10 after reads");
        chk("R10 sci after reads", 32'(sci_out), 32'(exp_sci()));
        chk("R10 smi after reads", 32'(smi_out), 32'(exp_smi()));

        // sweep every write value at every offset (R2..R9)
        for (int a = 0; a < 4; a++) begin
            for (int d = 0; d < 256; d++) begin
                wr(a, 8'(d));
                chk_regs("R2 R3 R4 R5 R6 R9 sweep");
            end
        end

        // pseudo-random mixed sequence biased to live offsets
        lfsr = 8'hA5;
        for (int n = 0; n < 600; n++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            wr((lfsr[7:6] == 2'b11) ? 2 : int'(lfsr[0]), lfsr);
            chk_regs("R3 R4 R5 R6 random");
        end

        report();
    end

endmodule